// File: doc/BRIEF.md
# Dual-Framing Serial Burst Transmitter

This block takes result words from an upstream filter and ships them to a host processor over a single serial data line. Words are gathered in groups of eight; each complete group becomes one burst of 128 bits, sent most significant bit first, with the first word of the group going out first. The bit clock is the system clock divided by `2*HALF_DIV`. One mode input chooses how the burst is framed for the host.

With `spi_sel_n` low, the block acts as an SPI master in clock mode 0. The serial clock idles low and toggles only during a burst. An active-low select frames the burst. With `spi_sel_n` high, the serial clock runs continuously. A one-bit-wide, active-high frame-sync pulse is raised together with the first data bit (zero bit delay), and the select stays high. In both modes data is launched on the falling edge of the serial clock and is meant to be sampled on the rising edge.

The controller is a three-state machine. ST_IDLE waits for a loaded burst. ST_IDLE moves to ST_LEAD on a rising-edge slot when a burst is pending in SPI mode. ST_IDLE moves straight to ST_SHIFT on a falling-edge slot when a burst is pending in frame-sync mode. ST_LEAD moves to ST_SHIFT on the next falling-edge slot. ST_SHIFT returns to ST_IDLE on the falling edge that follows the 128th bit. A group of eight is handed to the shifter in one step, and only when the shifter is free. A group completed while a burst is pending or in flight is discarded and raises a sticky overrun flag.

Top module: `serial_burst_tx`

## Requirements
- R1: During and right after reset: `sel_n`=1, `fsync`=0, `ser_clk`=0 (with `spi_sel_n`=0), `ser_data`=0 and `overrun`=0. Reset is the only thing that clears `overrun`.
- R2: `spi_sel_n`=0 selects SPI framing and `spi_sel_n`=1 selects frame-sync framing. `fsync` never pulses in SPI framing.
- R3: In SPI framing, `ser_clk` is low whenever `sel_n` is high. Each burst has exactly 128 rising edges of `ser_clk` while `sel_n` is low.
- R4: In SPI framing, `sel_n` falls exactly 2*HALF_DIV clock cycles before the first rising edge of `ser_clk`. It rises HALF_DIV cycles after the 128th rising edge, which is on the next falling edge.
- R5: Bits go out MSB first, word by word in arrival order. `ser_data` changes only while `ser_clk` is low, so it is stable across every high phase.
- R6: In frame-sync framing, `ser_clk` toggles continuously with a period of 2*HALF_DIV cycles, and `sel_n` stays high.
- R7: In frame-sync framing, `fsync` is high for exactly one bit period (2*HALF_DIV cycles), once per burst. It is high at the rising edge that samples the MSB of word 0.
- R8: Every eighth accepted word completes a group. The group is loaded into the shifter in one step. Words that arrive while a burst is in flight go to the next burst.
- R9: If a group completes while a burst is pending or in flight, `overrun` goes high and stays high, and that group is never sent.
- R10: `ser_data` is 0 outside bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Framing select: 0 = SPI, 1 = frame-sync |
| word_valid | input | 1 | One-cycle strobe for an incoming word |
| word_data | input | WORD_W | Incoming filter result word |
| ser_clk | output | 1 | Serial bit clock to the host |
| ser_data | output | 1 | Serial data, MSB first |
| sel_n | output | 1 | Active-low select (SPI framing only) |
| fsync | output | 1 | Active-high frame sync (frame-sync framing only) |
| overrun | output | 1 | Sticky flag: a completed group was dropped |

## Verification
The bench builds the block with its defaults: HALF_DIV=2, WORD_W=16 and BURST_WORDS=8. A bit period is then four system cycles, so the select lead time, the frame-sync width and the free-running clock rate can be counted exactly. A 128-bit burst lasts about 520 cycles, which leaves room for many bursts in both framings. That span is also long enough to push a second full group and a partial third group in while the first burst is still being shifted, which reaches the overrun and next-burst cases.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } sbt_state_e;
endpackage

// File: rtl/sbt_bitclk.sv
module sbt_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] div_cnt;
    logic          tick;

    assign tick     = (div_cnt == LAST);
    assign rise_evt = tick && !phase;
    assign fall_evt = tick && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            phase   <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            phase   <= ~phase;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R6: the phase flips only at a divider wrap
    assert_phase_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
endmodule

// File: rtl/sbt_stage.sv
module sbt_stage #(
    parameter int WORD_W      = 16,
    parameter int BURST_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [WORD_W-1:0]             in_data,
    input  logic                          busy,
    output logic                          load,
    output logic [WORD_W*BURST_WORDS-1:0] burst,
    output logic                          overrun
);
    localparam int BITS = WORD_W * BURST_WORDS;
    localparam int CW   = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BURST_WORDS - 1);

    logic [WORD_W-1:0] held [BURST_WORDS-1];
    logic [CW-1:0]     cnt;
    logic              group_done;

    assign group_done = in_valid && (cnt == LAST);
    assign load       = group_done && !busy;

    for (genvar i = 0; i < BURST_WORDS - 1; i++) begin : g_pack
        assign burst[BITS-1-i*WORD_W -: WORD_W] = held[i];
    end
    assign burst[WORD_W-1:0] = in_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            overrun <= 1'b0;
            for (int i = 0; i < BURST_WORDS - 1; i++) held[i] <= '0;
        end else if (in_valid) begin
            if (cnt == LAST) begin
                cnt <= '0;
                if (busy) overrun <= 1'b1;
            end else begin
                held[cnt] <= in_data;
                cnt       <= cnt + 1'b1;
            end
        end
    end

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_drop_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (group_done && busy) |=> overrun);
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/sbt_fsm.sv
module sbt_fsm
    import sbt_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BURST_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_n,
    input  logic                          phase,
    input  logic                          rise_evt,
    input  logic                          fall_evt,
    input  logic                          load,
    input  logic [WORD_W*BURST_WORDS-1:0] burst,
    output logic                          ser_clk,
    output logic                          ser_data,
    output logic                          sel_n,
    output logic                          fsync,
    output logic                          busy
);
    localparam int BITS = WORD_W * BURST_WORDS;
    localparam int BW   = $clog2(BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

    sbt_state_e      state, nxt;
    logic [BITS-1:0] shreg;
    logic [BW-1:0]   bit_cnt;
    logic            pending, gate, frame_q;
    logic            spi_go, frm_go;

    assign spi_go  = rise_evt && pending && !mode_n;
    assign frm_go  = fall_evt && pending && mode_n;
    assign busy    = pending || (state != ST_IDLE);
    assign ser_clk = frame_q ? phase : (phase & gate);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (spi_go) nxt = ST_LEAD;
                      else if (frm_go) nxt = ST_SHIFT;
            ST_LEAD:  if (fall_evt) nxt = ST_SHIFT;
            ST_SHIFT: if (fall_evt && bit_cnt == LAST_BIT) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            pending  <= 1'b0;
            gate     <= 1'b0;
            frame_q  <= 1'b0;
            ser_data <= 1'b0;
            sel_n    <= 1'b1;
            fsync    <= 1'b0;
        end else begin
            if (load) begin
                shreg   <= burst;
                pending <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (fall_evt) frame_q <= mode_n;
                    if (spi_go) begin
                        sel_n   <= 1'b0;
                        frame_q <= 1'b0;
                        pending <= 1'b0;
                    end else if (frm_go) begin
                        fsync    <= 1'b1;
                        ser_data <= shreg[BITS-1];
                        shreg    <= shreg << 1;
                        bit_cnt  <= '0;
                        pending  <= 1'b0;
                    end
                end
                ST_LEAD: if (fall_evt) begin
                    gate     <= 1'b1;
                    ser_data <= shreg[BITS-1];
                    shreg    <= shreg << 1;
                    bit_cnt  <= '0;
                end
                ST_SHIFT: if (fall_evt) begin
                    fsync <= 1'b0;
                    if (bit_cnt == LAST_BIT) begin
                        gate     <= 1'b0;
                        sel_n    <= 1'b1;
                        ser_data <= 1'b0;
                    end else begin
                        ser_data <= shreg[BITS-1];
                        shreg    <= shreg << 1;
                        bit_cnt  <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_desel_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_q && sel_n) |-> !ser_clk);
    assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ser_clk) && ser_clk) |-> $stable(ser_data));
    assert_fsync_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> (state == ST_SHIFT && bit_cnt == '0 && frame_q));
    assert_no_sel_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q |-> sel_n);
    assert_idle_data_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !fsync) |-> !ser_data);
endmodule

// File: rtl/serial_burst_tx.sv
module serial_burst_tx #(
    parameter int WORD_W      = 16,
    parameter int BURST_WORDS = 8,
    parameter int HALF_DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sel_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              sel_n,
    output logic              fsync,
    output logic              overrun
);
    localparam int BITS = WORD_W * BURST_WORDS;

    logic            phase, rise_evt, fall_evt;
    logic            load, busy;
    logic [BITS-1:0] burst;

    sbt_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    sbt_stage #(.WORD_W(WORD_W), .BURST_WORDS(BURST_WORDS)) u_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(word_valid), .in_data(word_data),
        .busy(busy), .load(load), .burst(burst), .overrun(overrun)
    );

    sbt_fsm #(.WORD_W(WORD_W), .BURST_WORDS(BURST_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_n(spi_sel_n), .phase(phase),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .load(load), .burst(burst),
        .ser_clk(ser_clk), .ser_data(ser_data), .sel_n(sel_n),
        .fsync(fsync), .busy(busy)
    );
endmodule

// File: tb/tb_serial_burst_tx.sv
module tb_serial_burst_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic clk = 0, rst_n = 0, spi_sel_n = 0, word_valid = 0;
    logic [15:0] word_data = '0;
    logic ser_clk, ser_data, sel_n, fsync, overrun;

    serial_burst_tx #(.WORD_W(16), .BURST_WORDS(8), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .word_valid(word_valid),
        .word_data(word_data), .ser_clk(ser_clk), .ser_data(ser_data),
        .sel_n(sel_n), .fsync(fsync), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, wd_cyc = 0;
    bit bench_frame = 0;
    int cyc = 0, nb = 0, bursts_done = 0, bits_at_end = 0;
    int rises = 0, rise_desel = 0, fs_rises = 0, bad_fs = 0, sel_in_frame = 0;
    int t_sel_fall = 0, t_first_rise = 0, t_last_rise = 0, t_sel_rise = 0;
    int fs_len = 0, last_fs_len = 0;
    bit act = 0, clk_prev = 0, sel_prev = 1, fs_prev = 0;
    logic [127:0] cap = '0, got_burst = '0;
    logic [15:0] exp_w [8];

    always @(posedge clk) wd_cyc++;

    // bus monitor acting as the host receiver
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            nb = 0; act = 0; clk_prev = 0; sel_prev = 1; fs_prev = 0;
        end else begin
            if (!sel_n && sel_prev) t_sel_fall = cyc;
            if (sel_n && !sel_prev && !bench_frame) begin
                t_sel_rise = cyc; bits_at_end = nb; got_burst = cap;
                bursts_done++; nb = 0;
            end
            if (ser_clk && !clk_prev) begin
                rises++;
                if (!bench_frame) begin
                    if (sel_n) rise_desel++;
                    else begin
                        if (nb == 0) t_first_rise = cyc;
                        t_last_rise = cyc;
                        cap = {cap[126:0], ser_data}; nb++;
                    end
                end else begin
                    if (fsync) begin
                        fs_rises++;
                        if (nb != 0) bad_fs++;
                        nb = 0; act = 1;
                    end
                    if (act) begin
                        cap = {cap[126:0], ser_data}; nb++;
                        if (nb == 128) begin
                            got_burst = cap; bursts_done++; act = 0; nb = 0;
                        end
                    end
                end
            end
            if (!bench_frame && fsync && !fs_prev) fs_rises++;
            if (fsync && !fs_prev) fs_len = 1;
            else if (fsync) fs_len++;
            if (!fsync && fs_prev) last_fs_len = fs_len;
            if (bench_frame && !sel_n) sel_in_frame++;
            clk_prev = ser_clk; sel_prev = sel_n; fs_prev = fsync;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act_v,
                         input logic [127:0] exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
        end
    endtask

    function automatic logic [127:0] pack8();
        logic [127:0] r = '0;
        for (int i = 0; i < 8; i++) r = {r[111:0], exp_w[i]};
        return r;
    endfunction

    task automatic send_word(input logic [15:0] d);
        @(negedge clk); word_valid = 1; word_data = d;
        @(negedge clk); word_valid = 0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic wait_bursts(input int n);
        while (bursts_done < n) @(negedge clk);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 8; i++) exp_w[i] = 16'($urandom());
    endtask

    task automatic fill_directed();
        exp_w[0] = 16'h8001; exp_w[1] = 16'h7FFE; exp_w[2] = 16'hFFFF; exp_w[3] = 16'h0000;
        exp_w[4] = 16'hA5A5; exp_w[5] = 16'h5A5A; exp_w[6] = 16'h0001; exp_w[7] = 16'h8000;
    endtask

    initial begin
        wait (wd_cyc >= 150000);
        fails++; tests++;
        $display("FAIL watchdog: got %0d cycles expected completion", wd_cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base, r0, fs0;
        logic [127:0] exp_a, exp_c;
        void'($urandom(32'h51A7E));
        repeat (5) @(negedge clk);
        check(sel_n && !fsync && !ser_clk && !ser_data && !overrun, "R1 reset outputs",
              {sel_n, fsync, ser_clk, ser_data, overrun}, 5'b10000);
        rst_n = 1;
        repeat (20) @(negedge clk);
        check(rise_desel == 0, "R3 idle clock low", rise_desel, 0);

        // SPI framing: directed then random bursts
        for (int b = 0; b < 3; b++) begin
            if (b == 0) fill_directed(); else fill_random();
            base = bursts_done;
            for (int i = 0; i < 8; i++) send_word(exp_w[i]);
            wait_bursts(base + 1);
            check(got_burst == pack8(), "R5 R8 SPI burst content", got_burst, pack8());
            check(bits_at_end == 128, "R3 rising edges per burst", bits_at_end, 128);
            check(t_first_rise - t_sel_fall == 2*HALF, "R4 select lead",
                  t_first_rise - t_sel_fall, 2*HALF);
            check(t_sel_rise - t_last_rise == HALF, "R4 select release",
                  t_sel_rise - t_last_rise, HALF);
            repeat (3) @(negedge clk);
            check(!ser_data, "R10 idle data", ser_data, 0);
        end
        check(rise_desel == 0, "R3 no clock while deselected", rise_desel, 0);
        check(fs_rises == 0, "R2 no fsync in SPI", fs_rises, 0);
        check(!overrun, "R9 no overrun in normal flow", overrun, 0);

        // overrun and mid-burst arrivals
        fill_random(); exp_a = pack8();
        base = bursts_done;
        for (int i = 0; i < 8; i++) send_word(exp_w[i]);
        fill_random();
        for (int i = 0; i < 8; i++) send_word(exp_w[i]);
        check(overrun, "R9 overrun raised", overrun, 1);
        fill_random(); exp_c = pack8();
        for (int i = 0; i < 3; i++) send_word(exp_w[i]);
        wait_bursts(base + 1);
        check(got_burst == exp_a, "R8 first burst intact", got_burst, exp_a);
        for (int i = 3; i < 8; i++) send_word(exp_w[i]);
        wait_bursts(base + 2);
        check(got_burst == exp_c, "R9 dropped group never sent", got_burst, exp_c);
        check(overrun, "R9 overrun sticky", overrun, 1);

        rst_n = 0; repeat (2) @(negedge clk);
        check(!overrun && sel_n, "R1 reset clears overrun", {overrun, sel_n}, 2'b01);
        rst_n = 1;

        // frame-sync framing
        spi_sel_n = 1; bench_frame = 1;
        repeat (10) @(negedge clk);
        r0 = rises;
        repeat (40) @(negedge clk);
        check(rises - r0 >= 9 && rises - r0 <= 11, "R6 free-running clock", rises - r0, 10);
        for (int b = 0; b < 3; b++) begin
            if (b == 1) fill_directed(); else fill_random();
            base = bursts_done; fs0 = fs_rises;
            for (int i = 0; i < 8; i++) send_word(exp_w[i]);
            wait_bursts(base + 1);
            check(got_burst == pack8(), "R5 R7 frame burst content", got_burst, pack8());
            check(fs_rises - fs0 == 1, "R7 one fsync per burst", fs_rises - fs0, 1);
            check(last_fs_len == 2*HALF, "R7 fsync width", last_fs_len, 2*HALF);
            repeat (2*HALF + 2) @(negedge clk);
            check(!ser_data, "R10 idle data frame mode", ser_data, 0);
        end
        check(bad_fs == 0, "R7 no fsync mid-burst", bad_fs, 0);
        check(sel_in_frame == 0, "R6 select stays high", sel_in_frame, 0);
        check(!overrun, "R9 no overrun frame mode", overrun, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule